// File: doc/BRIEF.md
# Dual-Stream FIFO Alignment Controller

Two camera paths that share a line-locked timing reference still reach the back end a few pixels apart, because the decoders in each path start with different latencies. Each path writes into its own FIFO, whose words hold 16 pixel bits plus the three sync/enable flags. Both FIFOs are drained on one common clock. This controller owns the write and read enables of both FIFOs and lines the two streams up without storing a frame.

A signed skew in pixel clocks says which stream is ahead. When capture starts, the controller opens the write enable of the leading stream first. It opens the lagging stream's write enable exactly |skew| clocks later, so both FIFO heads hold the same pixel index. The leading stream's data waits in its FIFO for that many extra clocks. Once both fill counts are non-zero, both reads are enabled together and stay locked. A ready flag reports this.

A realign request flushes both FIFOs for one cycle and runs the sequence again. A sticky error flag reports any write into a full FIFO and any read from an empty one.

Top module: `dual_stream_aligner`

## Requirements
- R1: While rst_n is low (asynchronous), wr_en and rd_en are 2'b00, ready and err are low, and fifo_clr is high.
- R2: Bit 0 of wr_en and rd_en serves stream A and bit 1 serves stream B. A skew of zero or more means B lags, so wr_en[0] opens first. A negative skew means A lags, so wr_en[1] opens first.
- R3: The lagging write enable opens exactly |skew| clock edges after the leading one. With zero skew, both open on the same edge.
- R4: rd_en only takes the values 2'b00 and 2'b11. Once ready is high, ready and rd_en = 2'b11 stay high until realign.
- R5: Count the first edge with rst_n high, or the edge after a realign edge, as edge 1. The leading write enable is high after edge 1. With both sources delivering, ready and rd_en rise after edge |skew|+3.
- R6: The controller enables reads only after an edge at which both fill counts were non-zero. While either count stays zero, ready stays low.
- R7: When the FIFO heads are read, both streams deliver the same pixel from the first read onward.
- R8: A skew magnitude above MAX_SKEW (64) is treated as MAX_SKEW with the same sign. A skew of exactly ±64 is absorbed without error.
- R9: An edge at which a read enable is high while that FIFO's fill count is zero sets err after that edge.
- R10: An edge at which a write enable is high while that FIFO's fill count is at least DEPTH (256) sets err. err stays high until realign or reset.
- R11: A realign pulse clears wr_en, rd_en, ready and err after its edge. It raises fifo_clr for one cycle and then reruns R2 to R6 with the skew present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common read/write clock of both FIFOs |
| rst_n | input | 1 | Asynchronous active-low reset |
| realign | input | 1 | Request to flush and rerun the hold-off sequence |
| skew | input | 8 | Signed skew in pixel clocks; positive means stream B lags |
| fill_a | input | 9 | Word count of the stream A FIFO |
| fill_b | input | 9 | Word count of the stream B FIFO |
| wr_en | output | 2 | Write enables, bit 0 stream A, bit 1 stream B |
| rd_en | output | 2 | Read enables, bit 0 stream A, bit 1 stream B |
| fifo_clr | output | 1 | Flush request to both FIFOs |
| ready | output | 1 | Both streams aligned and being read |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
The properties assume that each fill count reflects its FIFO's content as of the current edge and changes by at most one word per write and per read. They also assume that skew holds still in the cycle fifo_clr is high. The bench models both FIFOs with counts updated on the same edge as the enables. Each modelled source delivers one word per enabled clock and is paused only in scenarios that starve a FIFO on purpose. Skew and the physical offset of the modelled streams change only together with a reset or a realign pulse. The one test that drives a full count does so through an override of the fill input.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_WAIT = 2'd2,
      ST_RUN  = 2'd3
   } dsa_state_e;

   localparam logic [1:0] LANE_A = 2'b01;
   localparam logic [1:0] LANE_B = 2'b10;
   localparam logic [1:0] LANE_BOTH = 2'b11;
endpackage

// File: rtl/dsa_skew_mag.sv
module dsa_skew_mag #(
   parameter int SKEW_W   = 8,
   parameter int MAX_SKEW = 64,
   parameter bit CLAMP    = 1'b1,
   parameter int MAG_W    = 7
) (
   input  logic [SKEW_W-1:0] skew,
   output logic [MAG_W-1:0]  mag,
   output logic [1:0]        lead_vec
);
   import dsa_pkg::*;

   logic              neg;
   logic [SKEW_W-1:0] raw;

   assign neg      = skew[SKEW_W-1];
   assign raw      = neg ? (~skew + 1'b1) : skew;
   assign lead_vec = neg ? LANE_B : LANE_A;

   generate
      if (CLAMP) begin : g_clamp
         assign mag = (raw > SKEW_W'(MAX_SKEW)) ? MAG_W'(MAX_SKEW) : MAG_W'(raw);
      end else begin : g_pass
         assign mag = MAG_W'(raw);
      end
   endgenerate
endmodule

// File: rtl/dsa_holdoff.sv
module dsa_holdoff #(
   parameter int MAG_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             realign,
   input  logic [MAG_W-1:0] mag,
   input  logic [1:0]       lead_vec,
   input  logic             both_nz,
   output logic [1:0]       wr_q,
   output logic [1:0]       rd_q,
   output logic             rdy_q,
   output logic             clr_o
);
   import dsa_pkg::*;

   dsa_state_e       state;
   logic [MAG_W-1:0] cnt;

   assign clr_o = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         wr_q  <= '0;
         rd_q  <= '0;
         rdy_q <= 1'b0;
      end else if (realign) begin
         state <= ST_IDLE;
         cnt   <= '0;
         wr_q  <= '0;
         rd_q  <= '0;
         rdy_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (mag == '0) begin
                  wr_q  <= LANE_BOTH;
                  state <= ST_WAIT;
               end else begin
                  wr_q  <= lead_vec;
                  cnt   <= mag;
                  state <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (cnt == MAG_W'(1)) begin
                  wr_q  <= LANE_BOTH;
                  state <= ST_WAIT;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_WAIT: begin
               if (both_nz) begin
                  rd_q  <= LANE_BOTH;
                  rdy_q <= 1'b1;
                  state <= ST_RUN;
               end
            end
            default: ;
         endcase
      end
   end

   // R2: only the leading lane writes during the hold-off window
   p_hold_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |-> $onehot(wr_q));

   // R4: reads never run on one lane only
   p_rd_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_q) != 1);

   // R4: ready holds until a realign request
   p_ready_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_q && !realign) |=> rdy_q);

   // R6: reads start only after both counts were non-zero
   p_rd_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_q) |-> $past(both_nz));

   // R11: a realign request silences all enables
   p_realign_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      realign |=> (wr_q == 2'b00 && rd_q == 2'b00 && !rdy_q && clr_o));
endmodule

// File: rtl/dsa_level_guard.sv
module dsa_level_guard #(
   parameter int CNT_W = 9,
   parameter int DEPTH = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 realign,
   input  logic [1:0]           wr_en,
   input  logic [1:0]           rd_en,
   input  logic [1:0][CNT_W-1:0] fill,
   output logic                 err
);
   logic [1:0] uf;
   logic [1:0] of;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_lane
         assign uf[i] = rd_en[i] && (fill[i] == '0);
         assign of[i] = wr_en[i] && (fill[i] >= CNT_W'(DEPTH));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err <= 1'b0;
      else if (realign) err <= 1'b0;
      else              err <= err | (|uf) | (|of);
   end

   // R9: a read from an empty FIFO raises the flag
   p_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_en[0] && fill[0] == '0) || (rd_en[1] && fill[1] == '0)) && !realign |=> err);

   // R10: a write into a full FIFO raises the flag
   p_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en[0] && fill[0] >= CNT_W'(DEPTH)) || (wr_en[1] && fill[1] >= CNT_W'(DEPTH)))
      && !realign |=> err);

   // R10: the flag is sticky until realign
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !realign) |=> err);
endmodule

// File: rtl/dual_stream_aligner.sv
module dual_stream_aligner #(
   parameter int SKEW_W   = 8,
   parameter int CNT_W    = 9,
   parameter int DEPTH    = 256,
   parameter int MAX_SKEW = 64,
   parameter bit CLAMP    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              realign,
   input  logic [SKEW_W-1:0] skew,
   input  logic [CNT_W-1:0]  fill_a,
   input  logic [CNT_W-1:0]  fill_b,
   output logic [1:0]        wr_en,
   output logic [1:0]        rd_en,
   output logic              fifo_clr,
   output logic              ready,
   output logic              err
);
   localparam int MAG_W = CLAMP ? $clog2(MAX_SKEW + 1) : SKEW_W;

   generate
      if (MAX_SKEW >= DEPTH) begin : g_bad_skew
         $error("MAX_SKEW must be below DEPTH");
      end
      if (DEPTH >= (1 << CNT_W)) begin : g_bad_cnt
         $error("DEPTH must fit in CNT_W bits");
      end
      if (MAX_SKEW > (1 << (SKEW_W - 1))) begin : g_bad_w
         $error("SKEW_W too narrow for MAX_SKEW");
      end
      if (!CLAMP && ((1 << (SKEW_W - 1)) >= DEPTH)) begin : g_bad_pass
         $error("unclamped skew range exceeds DEPTH");
      end
   endgenerate

   logic [MAG_W-1:0]      mag;
   logic [1:0]            lead_vec;
   logic                  both_nz;
   logic [1:0][CNT_W-1:0] fill;

   assign both_nz = (fill_a != '0) && (fill_b != '0);
   assign fill    = {fill_b, fill_a};

   dsa_skew_mag #(
      .SKEW_W  (SKEW_W),
      .MAX_SKEW(MAX_SKEW),
      .CLAMP   (CLAMP),
      .MAG_W   (MAG_W)
   ) u_mag (
      .skew    (skew),
      .mag     (mag),
      .lead_vec(lead_vec)
   );

   dsa_holdoff #(
      .MAG_W(MAG_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .realign (realign),
      .mag     (mag),
      .lead_vec(lead_vec),
      .both_nz (both_nz),
      .wr_q    (wr_en),
      .rd_q    (rd_en),
      .rdy_q   (ready),
      .clr_o   (fifo_clr)
   );

   dsa_level_guard #(
      .CNT_W(CNT_W),
      .DEPTH(DEPTH)
   ) u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .realign(realign),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .fill   (fill),
      .err    (err)
   );

   // R1: flush request stays up while the controller is idle
   p_clr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |-> (wr_en == 2'b00 && rd_en == 2'b00 && !ready));
endmodule

// File: tb/tb_dual_stream_aligner.sv
`timescale 1ns/1ps
module tb_dual_stream_aligner;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              realign = 1'b0;
   logic signed [7:0] skew = '0;
   logic [8:0]        fill_a, fill_b;
   logic [1:0]        wr_en, rd_en;
   logic              fifo_clr, ready, err;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // FIFO and source model
   int mem_a [512];
   int mem_b [512];
   int wp_a = 0, rp_a = 0, wp_b = 0, rp_b = 0;
   int tick = 1000;
   int k_src = 0;
   bit src_a_on = 1'b1, src_b_on = 1'b1, ovr_a = 1'b0;

   always #4 clk = ~clk;

   dual_stream_aligner dut (
      .clk(clk), .rst_n(rst_n), .realign(realign), .skew(skew),
      .fill_a(fill_a), .fill_b(fill_b), .wr_en(wr_en), .rd_en(rd_en),
      .fifo_clr(fifo_clr), .ready(ready), .err(err)
   );

   assign fill_a = ovr_a ? 9'd256 : 9'(wp_a - rp_a);
   assign fill_b = 9'(wp_b - rp_b);

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      tick <= tick + 1;
      if (fifo_clr) begin
         wp_a <= 0; rp_a <= 0; wp_b <= 0; rp_b <= 0;
      end else begin
         if (wr_en[0] && src_a_on && (wp_a - rp_a) < 256) begin
            mem_a[wp_a % 512] <= tick;
            wp_a <= wp_a + 1;
         end
         if (rd_en[0] && wp_a != rp_a) rp_a <= rp_a + 1;
         if (wr_en[1] && src_b_on && (wp_b - rp_b) < 256) begin
            mem_b[wp_b % 512] <= tick - k_src;
            wp_b <= wp_b + 1;
         end
         if (rd_en[1] && wp_b != rp_b) rp_b <= rp_b + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic start(input int k_cfg, input int k_phys);
      @(negedge clk);
      rst_n = 1'b0;
      realign = 1'b0;
      skew = 8'(k_cfg);
      k_src = k_phys;
      src_a_on = 1'b1;
      src_b_on = 1'b1;
      ovr_a = 1'b0;
      step(3);
      rst_n = 1'b1;
   endtask

   // counts edges from edge 1 until ready, checks order and timing
   task automatic measure(input int k);
      int n = 0, n_wa = -1, n_wb = -1, n_rdy = -1;
      int m = (k < 0) ? -k : k;
      while (n < 200 && n_rdy < 0) begin
         step(1);
         n++;
         if (wr_en[0] && n_wa < 0) n_wa = n;
         if (wr_en[1] && n_wb < 0) n_wb = n;
         if (ready && n_rdy < 0) n_rdy = n;
      end
      if (k < 0) begin
         chk(n_wb == 1, "R2", "lane B leads", n_wb, 1);
         chk(n_wa - n_wb == m, "R3", "write offset", n_wa - n_wb, m);
      end else begin
         chk(n_wa == 1, "R2", "lane A leads", n_wa, 1);
         chk(n_wb - n_wa == m, "R3", "write offset", n_wb - n_wa, m);
      end
      chk(n_rdy == m + 3, "R5", "ready edge", n_rdy, m + 3);
      chk(rd_en == 2'b11, "R4", "both reads on", int'(rd_en), 3);
   endtask

   task automatic check_align(input int cycles);
      int mism = 0, gaps = 0, prev;
      chk(mem_a[rp_a % 512] == mem_b[rp_b % 512], "R7", "first pixel",
          mem_b[rp_b % 512], mem_a[rp_a % 512]);
      prev = mem_a[rp_a % 512];
      for (int i = 0; i < cycles; i++) begin
         step(1);
         if (mem_a[rp_a % 512] != mem_b[rp_b % 512]) mism++;
         if (mem_a[rp_a % 512] != prev + 1) gaps++;
         prev = mem_a[rp_a % 512];
         if (rd_en != 2'b11 || !ready) gaps++;
      end
      chk(mism == 0, "R7", "pixel mismatches", mism, 0);
      chk(gaps == 0, "R4", "locked read stream gaps", gaps, 0);
      chk(err == 1'b0, "R9", "no error while locked", int'(err), 0);
   endtask

   task automatic t_reset();
      start(5, 5);
      rst_n = 1'b0;
      #1;
      chk(wr_en == 2'b00 && rd_en == 2'b00, "R1", "enables in reset", int'({wr_en, rd_en}), 0);
      chk(!ready && !err && fifo_clr, "R1", "flags in reset", int'({ready, err, fifo_clr}), 1);
      rst_n = 1'b1;
      measure(5);
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      chk(wr_en == 2'b00 && !ready && fifo_clr, "R1", "async reset mid-run",
          int'({wr_en, ready, fifo_clr}), 1);
   endtask

   task automatic t_skew(input int k_cfg, input int k_phys);
      start(k_cfg, k_phys);
      measure(k_phys);
      check_align(60);
   endtask

   task automatic t_wait_fill();
      start(0, 0);
      src_b_on = 1'b0;
      rst_n = 1'b1;
      step(10);
      chk(!ready && rd_en == 2'b00, "R6", "no reads while B empty", int'({ready, rd_en}), 0);
      chk(wr_en == 2'b11, "R6", "writes open", int'(wr_en), 3);
      src_b_on = 1'b1;
      step(1);
      chk(!ready, "R6", "still waiting one edge", int'(ready), 0);
      step(1);
      chk(ready && rd_en == 2'b11, "R6", "reads after fill", int'({ready, rd_en}), 7);
   endtask

   task automatic t_underflow();
      start(0, 0);
      measure(0);
      src_b_on = 1'b0;
      step(2);
      chk(!err, "R9", "no error before empty read", int'(err), 0);
      step(1);
      chk(err, "R9", "empty read flagged", int'(err), 1);
      src_b_on = 1'b1;
      step(5);
      chk(err, "R10", "flag sticky", int'(err), 1);
      realign = 1'b1;
      step(1);
      realign = 1'b0;
      chk(!err, "R11", "realign clears flag", int'(err), 0);
   endtask

   task automatic t_overflow();
      start(2, 2);
      measure(2);
      chk(!err, "R10", "no error before full", int'(err), 0);
      ovr_a = 1'b1;
      step(1);
      ovr_a = 1'b0;
      chk(err, "R10", "full write flagged", int'(err), 1);
      step(3);
      chk(err, "R10", "overflow flag sticky", int'(err), 1);
   endtask

   task automatic t_realign();
      start(5, 5);
      measure(5);
      check_align(20);
      realign = 1'b1;
      skew = -8'sd3;
      k_src = -3;
      step(1);
      realign = 1'b0;
      chk(wr_en == 2'b00 && rd_en == 2'b00 && !ready, "R11", "enables cleared",
          int'({wr_en, rd_en, ready}), 0);
      chk(fifo_clr, "R11", "flush raised", int'(fifo_clr), 1);
      measure(-3);
      check_align(30);
   endtask

   initial begin
      t_reset();
      t_skew(5, 5);
      t_skew(-40, -40);
      t_skew(0, 0);
      t_skew(64, 64);     // R8 boundary
      t_skew(-100, -64);  // R8 clamp
      t_wait_fill();
      t_underflow();
      t_overflow();
      t_realign();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cyc > 100000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule